// File: doc/BRIEF.md
# Two-Frame Transmit Fetch Sequencer

This block decides when a transmit DMA engine may begin pulling the next frame from memory into the transmit FIFO. The MAC returns one status per frame, and the DMA needs that status before it can hand the frame's descriptor back to software. Because of this, the sequencer keeps a count of frames that are in flight, meaning granted but not yet released. It allows no more than two of them at once. Statuses retire frames strictly oldest first.

A mode input selects how aggressive fetching is. In serial mode, the DMA fetches a new frame only after the previous frame's status has come back and its descriptor has been released. In overlap mode, the DMA may begin fetching the second frame as soon as the first frame has been completely pushed into the FIFO, without waiting for any status. A third frame must still wait until the first frame's status retires it. The mode is captured only at frame boundaries.

The controller has three states. `ST_IDLE` means nothing is in flight. `ST_FETCH` means a frame is being pushed into the FIFO. `ST_PARKED` means one or two frames sit fully pushed, awaiting status. The transitions are:
- `ST_IDLE` to `ST_FETCH` on a grant.
- `ST_FETCH` to `ST_PARKED` on push completion.
- `ST_PARKED` to `ST_FETCH` on a grant in overlap mode.
- `ST_PARKED` to `ST_IDLE` when the last outstanding status is accepted and no grant is issued.

Top module: `txq_fetch_seq`

## Requirements
- R1: After reset, `fetch_grant` and `desc_release` are low and nothing is in flight. A frame that is available at the first clock edge after reset is granted at that edge in either mode, so `fetch_grant` is high in the following cycle.
- R2: `fetch_grant` is a one-cycle pulse. Once a grant is given, no further grant is issued until `push_done` for that frame has been sampled, even while `frame_avail` stays high.
- R3: At most MAX_FLIGHT (2) frames are ever granted and not yet released. In overlap mode, the third grant comes at the first edge that is later than both the edge where the second frame's `push_done` is sampled and the edge where the first frame's status is accepted.
- R4: With `overlap_en` at 0, a new grant comes at the edge after the one where the previous frame's status is accepted. `fetch_grant` therefore rises exactly one cycle after `desc_release`.
- R5: With `overlap_en` at 1, if `push_done` of the only in-flight frame is sampled at edge k, then the second frame is granted at edge k+1. It does not wait for status.
- R6: Each accepted `mac_stat_vld` gives exactly one `desc_release` pulse in the cycle after the edge that sampled it. Frames are released in grant order.
- R7: `mac_stat_vld` is ignored, with no `desc_release`, when no fully pushed frame is outstanding. This covers an empty sequencer and one whose only frame is still being pushed.
- R8: `push_done` is ignored while no fetch is in progress.
- R9: The mode is sampled only while nothing is in flight and at the edge where `push_done` ends a fetch. Raising `overlap_en` while a serial-mode frame waits for status does not allow an early grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| overlap_en | input | 1 | 1: fetch second frame after first is pushed; 0: serial fetch |
| frame_avail | input | 1 | A further frame is ready in memory |
| push_done | input | 1 | The frame being fetched is completely in the FIFO |
| mac_stat_vld | input | 1 | MAC returns status for the oldest pushed frame |
| fetch_grant | output | 1 | One-cycle pulse: DMA may start fetching a frame |
| desc_release | output | 1 | One-cycle pulse: oldest frame's descriptor may be released |

## Verification
The bench builds the block with the default MAX_FLIGHT of 2. This makes every occupancy reachable, from empty through the full two-frame case where a third frame must wait. The bench emulates a DMA whose push takes 1 to 4 cycles and a MAC whose status follows 1 to 6 cycles after each push, and it runs every such pair in both modes. For each run it computes the exact grant and release cycles of three back-to-back frames. The sweep reaches status arriving before, with or after the second push, and status coinciding with a grant. Directed sequences cover stray status, stray push completion and mode changes that occur between frame boundaries.

// File: rtl/txq_fetch_seq_pkg.sv
package txq_fetch_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_PARKED = 2'd2
    } seq_state_e;

endpackage

// File: rtl/txq_mode_hold.sv
// Captures the fetch mode only at frame boundaries: while nothing is in
// flight, and at the edge where the current fetch completes.
module txq_mode_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_in,
    input  logic is_idle,
    input  logic fetching,
    input  logic push_done,
    output logic mode_q
);

    logic boundary;

    always_comb begin
        boundary = is_idle || (fetching && push_done);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (boundary) begin
            mode_q <= mode_in;
        end
    end

endmodule

// File: rtl/txq_flight_ctr.sv
// Counts frames granted and not yet released; accepts MAC status for the
// oldest fully pushed frame and emits the descriptor-release strobe.
module txq_flight_ctr #(
    parameter int MAX_FLIGHT = 2,
    parameter int CW         = $clog2(MAX_FLIGHT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_grant,
    input  logic          fetching,
    input  logic          stat_vld,
    output logic [CW-1:0] cnt,
    output logic          stat_take,
    output logic          desc_release
);

    logic [CW-1:0] in_fetch;

    // A status may retire a frame only if at least one frame is already
    // completely in the FIFO (the one being fetched does not count).
    always_comb begin
        in_fetch  = CW'(fetching);
        stat_take = stat_vld && (cnt != in_fetch);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({take_grant, stat_take})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_release <= 1'b0;
        end else begin
            desc_release <= stat_take;
        end
    end

endmodule

// File: rtl/txq_grant_fsm.sv
// Grant controller: decides at each edge whether the DMA may begin a fetch.
module txq_grant_fsm
    import txq_fetch_seq_pkg::*;
#(
    parameter int MAX_FLIGHT = 2,
    parameter int CW         = $clog2(MAX_FLIGHT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_avail,
    input  logic          push_done,
    input  logic          mode_q,
    input  logic [CW-1:0] cnt,
    input  logic          stat_take,
    output seq_state_e    st,
    output logic          take_grant,
    output logic          fetch_grant
);

    localparam logic [CW-1:0] CAP = CW'(MAX_FLIGHT);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_e st_nx;
    logic       room;

    always_comb begin
        room       = (cnt == '0) || (mode_q && (cnt < CAP));
        take_grant = (st != ST_FETCH) && frame_avail && room;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (take_grant) st_nx = ST_FETCH;
            end
            ST_FETCH: begin
                if (push_done) st_nx = ST_PARKED;
            end
            ST_PARKED: begin
                if (take_grant)                    st_nx = ST_FETCH;
                else if (stat_take && cnt == ONE)  st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_grant <= 1'b0;
        else        fetch_grant <= take_grant;
    end

endmodule

// File: rtl/txq_fetch_seq.sv
module txq_fetch_seq
    import txq_fetch_seq_pkg::*;
#(
    parameter int MAX_FLIGHT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic overlap_en,
    input  logic frame_avail,
    input  logic push_done,
    input  logic mac_stat_vld,
    output logic fetch_grant,
    output logic desc_release
);

    localparam int CW = $clog2(MAX_FLIGHT + 1);

    seq_state_e    seq_st;
    logic [CW-1:0] flight_cnt;
    logic          mode_lat;
    logic          take_grant;
    logic          stat_take;
    logic          fetching;
    logic          is_idle;

    always_comb begin
        fetching = (seq_st == ST_FETCH);
        is_idle  = (seq_st == ST_IDLE);
    end

    txq_mode_hold u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_in   (overlap_en),
        .is_idle   (is_idle),
        .fetching  (fetching),
        .push_done (push_done),
        .mode_q    (mode_lat)
    );

    txq_flight_ctr #(
        .MAX_FLIGHT (MAX_FLIGHT),
        .CW         (CW)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_grant   (take_grant),
        .fetching     (fetching),
        .stat_vld     (mac_stat_vld),
        .cnt          (flight_cnt),
        .stat_take    (stat_take),
        .desc_release (desc_release)
    );

    txq_grant_fsm #(
        .MAX_FLIGHT (MAX_FLIGHT),
        .CW         (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_avail (frame_avail),
        .push_done   (push_done),
        .mode_q      (mode_lat),
        .cnt         (flight_cnt),
        .stat_take   (stat_take),
        .st          (seq_st),
        .take_grant  (take_grant),
        .fetch_grant (fetch_grant)
    );

endmodule

// File: rtl/txq_fetch_seq_chk.sv
module txq_fetch_seq_chk
    import txq_fetch_seq_pkg::*;
#(
    parameter int MAX_FLIGHT = 2,
    parameter int CW         = $clog2(MAX_FLIGHT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_grant,
    input logic          desc_release,
    input logic          mac_stat_vld,
    input logic [CW-1:0] cnt,
    input seq_state_e    st,
    input logic          mode_q
);

    localparam logic [CW-1:0] CAP = CW'(MAX_FLIGHT);

    // R3: occupancy never exceeds the cap
    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);

    // R3: a grant is never issued while the cap is already reached
    p_no_third_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> ($past(cnt) < CAP));

    // R1: the idle state means nothing in flight
    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (cnt == '0));

    // R2: grant is a single-cycle pulse
    p_grant_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |=> !fetch_grant);

    // R4: in serial mode a grant needs an empty sequencer
    p_serial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_grant && !$past(mode_q)) |-> ($past(cnt) == '0));

    // R6: every release follows a status one cycle earlier
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_release |-> $past(mac_stat_vld));

endmodule

bind txq_fetch_seq txq_fetch_seq_chk #(
    .MAX_FLIGHT (MAX_FLIGHT),
    .CW         (CW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_grant  (fetch_grant),
    .desc_release (desc_release),
    .mac_stat_vld (mac_stat_vld),
    .cnt          (flight_cnt),
    .st           (seq_st),
    .mode_q       (mode_lat)
);

// File: tb/txq_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module txq_fetch_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic overlap_en;
    logic frame_avail;
    logic push_done;
    logic mac_stat_vld;
    logic fetch_grant;
    logic desc_release;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    txq_fetch_seq #(.MAX_FLIGHT(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .overlap_en   (overlap_en),
        .frame_avail  (frame_avail),
        .push_done    (push_done),
        .mac_stat_vld (mac_stat_vld),
        .fetch_grant  (fetch_grant),
        .desc_release (desc_release)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        rst_n        = 1'b0;
        overlap_en   = mode;
        frame_avail  = 1'b0;
        push_done    = 1'b0;
        mac_stat_vld = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    // DMA/MAC emulator: three frames, push takes plen cycles after the
    // grant, status follows dly cycles after each push.
    task automatic sweep_run(input logic mode, input int plen, input int dly);
        int g_t[3];
        int r_t[3];
        int ng = 0;
        int nr = 0;
        int extra = 0;
        int nxt;
        int e2;
        int e3;
        int p2;
        int s1;
        do_reset(mode);
        frame_avail = 1'b1;
        for (int i = 0; i < 60; i++) begin
            step();
            if (fetch_grant) begin
                if (ng < 3) begin g_t[ng] = cyc; ng++; end
                else extra++;
            end
            if (desc_release) begin
                if (nr < 3) begin r_t[nr] = cyc; nr++; end
                else extra++;
            end
            nxt = cyc + 1;
            push_done    = 1'b0;
            mac_stat_vld = 1'b0;
            for (int k = 0; k < ng; k++) begin
                if (g_t[k] + plen == nxt)       push_done    = 1'b1;
                if (g_t[k] + plen + dly == nxt) mac_stat_vld = 1'b1;
            end
            frame_avail = (ng < 3);
        end
        chk("R2 grant count", ng + extra, 3);
        chk("R6 release count", nr + extra, 3);
        if (ng == 3 && nr == 3) begin
            if (mode) begin
                e2 = g_t[0] + plen + 1;                      // R5
                p2 = e2 + plen;
                s1 = g_t[0] + plen + dly;
                e3 = ((p2 > s1) ? p2 : s1) + 1;              // R3
                chk("R5 second grant cycle", g_t[1], e2);
                chk("R3 third grant cycle", g_t[2], e3);
            end else begin
                e2 = g_t[0] + plen + dly + 1;                // R4
                e3 = g_t[1] + plen + dly + 1;
                chk("R4 second grant cycle", g_t[1], e2);
                chk("R4 third grant cycle", g_t[2], e3);
            end
            for (int k = 0; k < 3; k++)
                chk("R6 release cycle", r_t[k], g_t[k] + plen + dly);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state and first grant
        do_reset(1'b0);
        chk("R1 grant after reset", fetch_grant, 0);
        chk("R1 release after reset", desc_release, 0);
        frame_avail = 1'b1;
        step();
        chk("R1 first grant", fetch_grant, 1);
        step();
        chk("R2 grant pulse width", fetch_grant, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R2 no grant while fetching", fetch_grant, 0);
        end
        frame_avail = 1'b0;
        // R7 status while only frame is still being pushed
        mac_stat_vld = 1'b1;
        step();
        mac_stat_vld = 1'b0;
        step();
        chk("R7 status during push", desc_release, 0);
        push_done = 1'b1;
        step();
        push_done = 1'b0;
        mac_stat_vld = 1'b1;
        step();
        mac_stat_vld = 1'b0;
        chk("R6 release after status", desc_release, 1);
        step();
        chk("R6 release single pulse", desc_release, 0);
        // R7 status while empty
        mac_stat_vld = 1'b1;
        step();
        mac_stat_vld = 1'b0;
        chk("R7 status while empty", desc_release, 0);
        // R8 stray push completion
        push_done = 1'b1;
        step();
        push_done = 1'b0;
        mac_stat_vld = 1'b1;
        step();
        mac_stat_vld = 1'b0;
        chk("R8 stray push no release", desc_release, 0);
        frame_avail = 1'b1;
        step();
        frame_avail = 1'b0;
        chk("R8 grant from empty", fetch_grant, 1);

        // R9 mode raised while a serial frame waits for status
        do_reset(1'b0);
        frame_avail = 1'b1;
        step();
        frame_avail = 1'b0;
        chk("R1 grant serial", fetch_grant, 1);
        push_done = 1'b1;
        step();
        push_done  = 1'b0;
        overlap_en = 1'b1;
        frame_avail = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R9 no early grant", fetch_grant, 0);
        end
        mac_stat_vld = 1'b1;
        step();
        mac_stat_vld = 1'b0;
        chk("R4 release before grant", desc_release, 1);
        chk("R4 no grant with release", fetch_grant, 0);
        step();
        frame_avail = 1'b0;
        chk("R4 grant after release", fetch_grant, 1);

        // Sweep over push length, status delay and mode
        for (int m = 0; m < 2; m++)
            for (int pl = 1; pl <= 4; pl++)
                for (int d = 1; d <= 6; d++)
                    sweep_run(m[0], pl, d);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule